// File: doc/BRIEF.md
# E1 HDLC Time Slot Gate

This block decides, bit by bit, which bits of a 2.048 Mbit/s E1 stream belong to each of three HDLC channels. An upstream frame-aligned counter supplies the current time slot (0 to 31) and the bit index (0 to 7). It also gives a one-cycle bit-valid pulse, and a frame-start flag marks the first bit of each frame. For every channel the gate raises a receive-side and a transmit-side strobe during the bit-valid cycle of each bit that the channel owns. It adds no latency, so the HDLC engines can sample the line bit in the same cycle.

Channel 1 has two 32-bit slot bitmaps, one for receive and one for transmit. The bitmap is four bytes with the most significant bit first, so slot 0 sits at the top bit of the word. Channels 2 and 3 each name a single slot, which both directions share. One eight-bit mask, common to all three channels, picks which bit positions inside a chosen slot are used. Each channel can also be limited to even frames, odd frames, or both. The block holds all configuration in shadow copies that it reloads at each frame start, so software writes land cleanly on a frame boundary.

Top module: `hdlc_slot_gate`

## Requirements
- R1: After reset all strobes stay low, even on valid bits, until the first bit-valid pulse that carries frame start.
- R2: Channel 1 receive strobe is raised only for slots whose bit in the receive map is 1, where slot s maps to map bit (31 - s): byte 3 bit 7 is slot 0 and byte 0 bit 0 is slot 31.
- R3: Channel 1 transmit strobe follows the transmit map with the same bit ordering, independently of the receive map.
- R4: Channels 2 and 3 (selector index 0 and 1) each use the one slot whose number equals their 5-bit selector, and their receive and transmit strobes are always equal.
- R5: A selector value of 0 disables that channel: neither strobe is ever raised, including in slot 0.
- R6: A bit with index k (0 = first bit of the slot) is used by any channel only if mask bit k is 1.
- R7: Frame select per channel: 2'b01 uses even frames only, 2'b10 odd frames only, 2'b00 and 2'b11 both. The first frame after reset is frame 0 (even), and parity alternates at every frame start.
- R8: Configuration inputs are sampled at the frame-start bit and applied from that bit on. Changes made inside a frame have no effect until the next frame start.
- R9: Strobes are raised only in cycles with bit-valid high, so each qualifying bit gives exactly one strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_valid_i | input | 1 | One-cycle pulse per line bit |
| frame_start_i | input | 1 | Marks the first bit of a frame, qualified by bit_valid_i |
| slot_i | input | 5 | Current time slot number |
| bit_idx_i | input | 3 | Bit index inside the slot, 0 first |
| ch1_rx_map_i | input | 32 | Channel 1 receive slot map, bit 31 = slot 0 |
| ch1_tx_map_i | input | 32 | Channel 1 transmit slot map, bit 31 = slot 0 |
| slot_sel_i | input | 2x5 | Single-slot selectors, [0] channel 2, [1] channel 3, 0 = off |
| bit_mask_i | input | 8 | Bit k = 1 uses bit index k |
| frame_sel_i | input | 3x2 | Frame select per channel, [0] channel 1 |
| rx_en_o | output | 3 | Receive use strobes, bit 0 = channel 1 |
| tx_en_o | output | 3 | Transmit use strobes, bit 0 = channel 1 |

## Verification
Each stimulus is a full 256-bit frame, and every valid bit and every idle cycle is compared against a model that keeps its own frame-latched copy of the configuration. Sparse asymmetric receive and transmit maps (first, last and byte-edge slots) tell a correct bit order from a byte-swapped or bit-reversed one, and they also separate the two directions. Selectors at 0, at a middle slot and at slot 31, together with masks that keep only the edge bits, catch off-by-one slot and bit decoding. Alternating-frame runs and a configuration change at mid-frame tell a correct parity start and shadow reload from a parity that is inverted or a reload that happens at once.

// File: rtl/hsg_pkg.sv
package hsg_pkg;
  typedef enum logic [1:0] {
    FSEL_BOTH = 2'b00,
    FSEL_EVEN = 2'b01,
    FSEL_ODD  = 2'b10,
    FSEL_ANY  = 2'b11
  } fsel_e;
endpackage

// File: rtl/hsg_cfg_hold.sv
module hsg_cfg_hold #(
  parameter int NUM_SLOTS     = 32,
  parameter int BITS_PER_SLOT = 8,
  parameter int NUM_SINGLE    = 2,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int NUM_CH = NUM_SINGLE + 1
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  bit_valid_i,
  input  logic                                  frame_start_i,
  input  logic [NUM_SLOTS-1:0]                  rx_map_i,
  input  logic [NUM_SLOTS-1:0]                  tx_map_i,
  input  logic [NUM_SINGLE-1:0][SLOT_W-1:0]     sel_i,
  input  logic [BITS_PER_SLOT-1:0]              mask_i,
  input  logic [NUM_CH-1:0][1:0]                fsel_i,
  output logic [NUM_SLOTS-1:0]                  rx_map_o,
  output logic [NUM_SLOTS-1:0]                  tx_map_o,
  output logic [NUM_SINGLE-1:0][SLOT_W-1:0]     sel_o,
  output logic [BITS_PER_SLOT-1:0]              mask_o,
  output logic [NUM_CH-1:0][1:0]                fsel_o,
  output logic                                  odd_frame_o,
  output logic                                  live_o
);
  logic                              load;
  logic [NUM_SLOTS-1:0]              rx_map_q, tx_map_q;
  logic [NUM_SINGLE-1:0][SLOT_W-1:0] sel_q;
  logic [BITS_PER_SLOT-1:0]          mask_q;
  logic [NUM_CH-1:0][1:0]            fsel_q;
  logic                              par_q, synced_q;

  assign load = bit_valid_i & frame_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_map_q <= '0;
      tx_map_q <= '0;
      sel_q    <= '0;
      mask_q   <= '0;
      fsel_q   <= '0;
      par_q    <= 1'b1;  // first frame start flips to even
      synced_q <= 1'b0;
    end else if (load) begin
      rx_map_q <= rx_map_i;
      tx_map_q <= tx_map_i;
      sel_q    <= sel_i;
      mask_q   <= mask_i;
      fsel_q   <= fsel_i;
      par_q    <= ~par_q;
      synced_q <= 1'b1;
    end
  end

  // frame-start bit already uses the new settings
  always_comb begin
    if (load) begin
      rx_map_o    = rx_map_i;
      tx_map_o    = tx_map_i;
      sel_o       = sel_i;
      mask_o      = mask_i;
      fsel_o      = fsel_i;
      odd_frame_o = ~par_q;
    end else begin
      rx_map_o    = rx_map_q;
      tx_map_o    = tx_map_q;
      sel_o       = sel_q;
      mask_o      = mask_q;
      fsel_o      = fsel_q;
      odd_frame_o = par_q;
    end
  end

  assign live_o = synced_q | load;
endmodule

// File: rtl/hsg_slot_match.sv
module hsg_slot_match #(
  parameter int NUM_SLOTS  = 32,
  parameter int NUM_SINGLE = 2,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int NUM_CH = NUM_SINGLE + 1
) (
  input  logic [SLOT_W-1:0]                 slot_i,
  input  logic [NUM_SLOTS-1:0]              rx_map_i,
  input  logic [NUM_SLOTS-1:0]              tx_map_i,
  input  logic [NUM_SINGLE-1:0][SLOT_W-1:0] sel_i,
  output logic [NUM_CH-1:0]                 rx_hit_o,
  output logic [NUM_CH-1:0]                 tx_hit_o
);
  logic [SLOT_W-1:0] rev_idx;

  // map is MSB-first: slot 0 at the top bit
  assign rev_idx = SLOT_W'(NUM_SLOTS - 1) - slot_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    if (c == 0) begin : g_map
      assign rx_hit_o[c] = rx_map_i[rev_idx];
      assign tx_hit_o[c] = tx_map_i[rev_idx];
    end else begin : g_single
      logic hit;
      assign hit         = (sel_i[c-1] != '0) && (sel_i[c-1] == slot_i);
      assign rx_hit_o[c] = hit;
      assign tx_hit_o[c] = hit;
    end
  end
endmodule

// File: rtl/hdlc_slot_gate.sv
module hdlc_slot_gate
  import hsg_pkg::*;
#(
  parameter int NUM_SLOTS     = 32,
  parameter int BITS_PER_SLOT = 8,
  parameter int NUM_SINGLE    = 2,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int BIT_W  = $clog2(BITS_PER_SLOT),
  localparam int NUM_CH = NUM_SINGLE + 1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              bit_valid_i,
  input  logic                              frame_start_i,
  input  logic [SLOT_W-1:0]                 slot_i,
  input  logic [BIT_W-1:0]                  bit_idx_i,
  input  logic [NUM_SLOTS-1:0]              ch1_rx_map_i,
  input  logic [NUM_SLOTS-1:0]              ch1_tx_map_i,
  input  logic [NUM_SINGLE-1:0][SLOT_W-1:0] slot_sel_i,
  input  logic [BITS_PER_SLOT-1:0]          bit_mask_i,
  input  logic [NUM_CH-1:0][1:0]            frame_sel_i,
  output logic [NUM_CH-1:0]                 rx_en_o,
  output logic [NUM_CH-1:0]                 tx_en_o
);
  logic [NUM_SLOTS-1:0]              rx_map_a, tx_map_a;
  logic [NUM_SINGLE-1:0][SLOT_W-1:0] sel_a;
  logic [BITS_PER_SLOT-1:0]          mask_a;
  logic [NUM_CH-1:0][1:0]            fsel_a;
  logic                              odd_frame, live;
  logic [NUM_CH-1:0]                 rx_hit, tx_hit, frame_ok;
  logic                              bit_ok;

  hsg_cfg_hold #(
    .NUM_SLOTS(NUM_SLOTS), .BITS_PER_SLOT(BITS_PER_SLOT), .NUM_SINGLE(NUM_SINGLE)
  ) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bit_valid_i  (bit_valid_i),
    .frame_start_i(frame_start_i),
    .rx_map_i     (ch1_rx_map_i),
    .tx_map_i     (ch1_tx_map_i),
    .sel_i        (slot_sel_i),
    .mask_i       (bit_mask_i),
    .fsel_i       (frame_sel_i),
    .rx_map_o     (rx_map_a),
    .tx_map_o     (tx_map_a),
    .sel_o        (sel_a),
    .mask_o       (mask_a),
    .fsel_o       (fsel_a),
    .odd_frame_o  (odd_frame),
    .live_o       (live)
  );

  hsg_slot_match #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_SINGLE(NUM_SINGLE)
  ) u_match (
    .slot_i  (slot_i),
    .rx_map_i(rx_map_a),
    .tx_map_i(tx_map_a),
    .sel_i   (sel_a),
    .rx_hit_o(rx_hit),
    .tx_hit_o(tx_hit)
  );

  assign bit_ok = mask_a[bit_idx_i];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_frame
    always_comb begin
      unique case (fsel_a[c])
        FSEL_EVEN: frame_ok[c] = ~odd_frame;
        FSEL_ODD:  frame_ok[c] = odd_frame;
        default:   frame_ok[c] = 1'b1;
      endcase
    end
    assign rx_en_o[c] = bit_valid_i & live & bit_ok & frame_ok[c] & rx_hit[c];
    assign tx_en_o[c] = bit_valid_i & live & bit_ok & frame_ok[c] & tx_hit[c];
  end
endmodule

// File: rtl/hsg_checker.sv
module hsg_checker #(
  parameter int NUM_SLOTS     = 32,
  parameter int BITS_PER_SLOT = 8,
  parameter int NUM_SINGLE    = 2,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int BIT_W  = $clog2(BITS_PER_SLOT),
  localparam int NUM_CH = NUM_SINGLE + 1
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic                              bit_valid_i,
  input logic                              frame_start_i,
  input logic [SLOT_W-1:0]                 slot_i,
  input logic [BIT_W-1:0]                  bit_idx_i,
  input logic [NUM_SLOTS-1:0]              ch1_rx_map_i,
  input logic [NUM_SLOTS-1:0]              ch1_tx_map_i,
  input logic [NUM_SINGLE-1:0][SLOT_W-1:0] slot_sel_i,
  input logic [BITS_PER_SLOT-1:0]          bit_mask_i,
  input logic [NUM_CH-1:0]                 rx_en_o,
  input logic [NUM_CH-1:0]                 tx_en_o
);
  logic              seen_q;
  logic              fs_bit;
  logic [SLOT_W-1:0] map_idx;

  assign fs_bit  = bit_valid_i & frame_start_i;
  assign map_idx = SLOT_W'(NUM_SLOTS - 1) - slot_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     seen_q <= 1'b0;
    else if (fs_bit) seen_q <= 1'b1;
  end

  AST_QUIET_BEFORE_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seen_q && !fs_bit) |-> (rx_en_o == '0 && tx_en_o == '0)); // R1
  AST_CH1_RX_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_bit && !ch1_rx_map_i[map_idx]) |-> !rx_en_o[0]); // R2
  AST_CH1_TX_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_bit && !ch1_tx_map_i[map_idx]) |-> !tx_en_o[0]); // R3
  AST_SINGLE_SHARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_en_o[NUM_CH-1:1] == tx_en_o[NUM_CH-1:1]); // R4
  AST_SEL_ZERO_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_bit && slot_sel_i[0] == '0) |-> !rx_en_o[1]); // R5
  AST_MASKED_BIT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_bit && !bit_mask_i[bit_idx_i]) |-> (rx_en_o == '0 && tx_en_o == '0)); // R6
  AST_IDLE_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_i |-> (rx_en_o == '0 && tx_en_o == '0)); // R9
  AST_STROBE_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_o != '0 || tx_en_o != '0) |-> bit_valid_i); // R9
endmodule

bind hdlc_slot_gate hsg_checker #(
  .NUM_SLOTS(NUM_SLOTS), .BITS_PER_SLOT(BITS_PER_SLOT), .NUM_SINGLE(NUM_SINGLE)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bit_valid_i  (bit_valid_i),
  .frame_start_i(frame_start_i),
  .slot_i       (slot_i),
  .bit_idx_i    (bit_idx_i),
  .ch1_rx_map_i (ch1_rx_map_i),
  .ch1_tx_map_i (ch1_tx_map_i),
  .slot_sel_i   (slot_sel_i),
  .bit_mask_i   (bit_mask_i),
  .rx_en_o      (rx_en_o),
  .tx_en_o      (tx_en_o)
);

// File: tb/hdlc_slot_gate_tb.sv
`timescale 1ns/1ps
module hdlc_slot_gate_tb;
  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bv = 1'b0, fs = 1'b0;
  logic [4:0]      slot = '0;
  logic [2:0]      bidx = '0;
  logic [31:0]     rx_map = '0, tx_map = '0;
  logic [1:0][4:0] sel = '0;
  logic [7:0]      mask = '0;
  logic [2:0][1:0] fsel = '0;
  logic [2:0]      rx_en, tx_en;

  // values the model latched at the last frame start
  logic [31:0]     a_rx, a_tx;
  logic [1:0][4:0] a_sel;
  logic [7:0]      a_mask;
  logic [2:0][1:0] a_fsel;
  // pending values written mid-frame
  logic [31:0]     p_rx, p_tx;
  logic [1:0][4:0] p_sel;
  logic [7:0]      p_mask;
  logic [2:0][1:0] p_fsel;

  bit synced;
  bit cur_odd;
  int fcount;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  hdlc_slot_gate u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_valid_i(bv), .frame_start_i(fs),
    .slot_i(slot), .bit_idx_i(bidx), .ch1_rx_map_i(rx_map), .ch1_tx_map_i(tx_map),
    .slot_sel_i(sel), .bit_mask_i(mask), .frame_sel_i(fsel),
    .rx_en_o(rx_en), .tx_en_o(tx_en)
  );

  task automatic check(input string tag, input logic [5:0] got, input logic [5:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s slot=%0d bit=%0d {rx,tx} got=%b exp=%b", tag, slot, bidx, got, exp);
    end
  endtask

  function automatic bit exp_en(input int ch, input bit tx, input int s, input int b);
    if (!synced) return 1'b0;
    if (!a_mask[b]) return 1'b0;
    if (a_fsel[ch] == 2'b01 && cur_odd) return 1'b0;
    if (a_fsel[ch] == 2'b10 && !cur_odd) return 1'b0;
    if (ch == 0) return tx ? a_tx[31-s] : a_rx[31-s];
    return (a_sel[ch-1] != 5'd0) && (int'(a_sel[ch-1]) == s);
  endfunction

  task automatic run_frame(input string tag, input bit no_fs, input bit mid_change);
    for (int s = 0; s < 32; s++) begin
      for (int b = 0; b < 8; b++) begin
        logic [5:0] e;
        @(negedge clk);
        slot = 5'(s); bidx = 3'(b); bv = 1'b1;
        fs = !no_fs && s == 0 && b == 0;
        if (fs) begin
          a_rx = rx_map; a_tx = tx_map; a_sel = sel; a_mask = mask; a_fsel = fsel;
          synced = 1'b1; cur_odd = fcount[0]; fcount++;
        end
        if (mid_change && s == 16 && b == 0) begin
          rx_map = p_rx; tx_map = p_tx; sel = p_sel; mask = p_mask; fsel = p_fsel;
        end
        #2;
        for (int c = 0; c < 3; c++) begin
          e[3+c] = exp_en(c, 1'b0, s, b);
          e[c]   = exp_en(c, 1'b1, s, b);
        end
        check(tag, {rx_en, tx_en}, e);
        @(negedge clk);
        bv = 1'b0; fs = 1'b0;
        #2;
        check("R9 idle", {rx_en, tx_en}, 6'b0);
      end
    end
  endtask

  task automatic set_cfg(input logic [31:0] r, input logic [31:0] t, input logic [4:0] s2,
                         input logic [4:0] s3, input logic [7:0] m, input logic [5:0] f);
    rx_map = r; tx_map = t; sel[0] = s2; sel[1] = s3; mask = m; fsel = f;
  endtask

  task automatic t_reset_presync();
    rst_n = 1'b0;
    set_cfg('1, '1, 5'd3, 5'd9, 8'hFF, 6'b0);
    repeat (3) @(negedge clk);
    #2;
    check("R1 reset", {rx_en, tx_en}, 6'b0);
    rst_n = 1'b1;
    synced = 1'b0; fcount = 0;
    run_frame("R1 presync", 1'b1, 1'b0);
  endtask

  task automatic t_ch1_maps();
    set_cfg(32'h8001_0081, 32'h0180_8000, 5'd0, 5'd0, 8'hFF, 6'b0);
    run_frame("R2 R3 maps a", 1'b0, 1'b0);
    set_cfg(32'h0000_0001, 32'h8000_0000, 5'd0, 5'd0, 8'hFF, 6'b0);
    run_frame("R2 R3 maps b", 1'b0, 1'b0);
  endtask

  task automatic t_single();
    set_cfg('0, '0, 5'd5, 5'd31, 8'hFF, 6'b0);
    run_frame("R4 single", 1'b0, 1'b0);
    set_cfg('0, '0, 5'd1, 5'd16, 8'hFF, 6'b0);
    run_frame("R4 single b", 1'b0, 1'b0);
  endtask

  task automatic t_disable();
    set_cfg(32'h8000_0000, 32'h8000_0000, 5'd0, 5'd0, 8'hFF, 6'b0);
    run_frame("R5 sel zero", 1'b0, 1'b0);
  endtask

  task automatic t_mask();
    set_cfg(32'hFFFF_FFFF, 32'h0F0F_0F0F, 5'd7, 5'd30, 8'h81, 6'b0);
    run_frame("R6 mask edge", 1'b0, 1'b0);
    set_cfg(32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd2, 5'd3, 8'h24, 6'b0);
    run_frame("R6 mask mid", 1'b0, 1'b0);
  endtask

  task automatic t_frames();
    // ch1 even, ch2 odd, ch3 both
    set_cfg(32'h00FF_0000, 32'h00FF_0000, 5'd4, 5'd20, 8'hFF, {2'b11, 2'b10, 2'b01});
    for (int i = 0; i < 3; i++) run_frame("R7 parity", 1'b0, 1'b0);
    set_cfg(32'h00FF_0000, 32'h0000_FF00, 5'd4, 5'd20, 8'hFF, {2'b01, 2'b00, 2'b10});
    run_frame("R7 parity b", 1'b0, 1'b0);
  endtask

  task automatic t_midframe();
    set_cfg(32'hFFFF_FFFF, '0, 5'd20, 5'd0, 8'hFF, 6'b0);
    p_rx = '0; p_tx = 32'hFFFF_FFFF; p_sel[0] = 5'd0; p_sel[1] = 5'd25;
    p_mask = 8'h0F; p_fsel = 6'b0;
    run_frame("R8 mid change", 1'b0, 1'b1);
    run_frame("R8 next frame", 1'b0, 1'b0);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset_presync();
    t_ch1_maps();
    t_single();
    t_disable();
    t_mask();
    t_frames();
    t_midframe();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule